// File: doc/BRIEF.md
# DMA Line-Chunking Request Sequencer

This block takes one DMA transfer at a time and turns it into a series of memory requests. A requester gives a start byte address, a byte count and a direction. The block then issues requests that each stay inside one cache line. The first request is cut short so that it ends on a line boundary. Every later request starts on a line boundary and covers up to a full line. Only one request is outstanding at any time. The next one goes out only after the memory side returns a full read line or a write acknowledge.

A local byte buffer of `MAX_LEN` entries serves both directions. Before a write transfer, the requester fills the buffer through a byte write port. After a read transfer, it collects the result through a byte read port. The block gives its answer to a request in the same cycle, through a status code. A transfer that arrives while another is still running is turned away. The block marks the end of a transfer with a one-cycle completion pulse.

Top module: `dma_line_seq`

## Requirements
- R1: After reset, `busy`, `mreq_valid` and `xfer_done` are all 0.
- R2: A request is accepted when it arrives while idle, has `req_type` 2'b00 (load) or 2'b01 (store), and has a length from 1 to `MAX_LEN`. In that cycle `req_status` is 2'd1 (issued). `busy` is 1 from the next cycle, and the first memory request follows.
- R3: A request that arrives while `busy` is 1 gets `req_status` 2'd2 (full). It has no effect on the transfer in progress: the addresses, lengths and data of that transfer are unchanged.
- R4: While idle, a request is rejected if `req_type` is 2'b10 or 2'b11, or if its length is 0 or greater than `MAX_LEN`. It gets `req_status` 2'd3 (error). The block stays idle and issues no memory request. When `req_valid` is 0, `req_status` is 2'd0.
- R5: The first memory request has address equal to the start address. Its length is the smaller of the transfer length and `LINE_BYTES` minus (start address modulo `LINE_BYTES`).
- R6: Every later request has address equal to the start address plus the bytes already completed, and that address is line-aligned. Its length is the smaller of the remaining bytes and `LINE_BYTES`.
- R7: At most one memory request is outstanding. A request stays valid and unchanged until `mreq_ready` is 1. No new request is raised until a response (`mrsp_valid` while `mrsp_ready`) has been taken.
- R8: `xfer_done` pulses for one cycle, in the cycle after the response that completes the last byte. `busy` is already 0 in that cycle, and a new request presented in that cycle is accepted.
- R9: For a read, the response to a chunk writes line byte lanes from the chunk offset onward into buffer entries starting at the bytes completed before that chunk. The chunk offset is the start offset for the first chunk and 0 for later chunks. Buffer entry j, read through `buf_ridx`/`buf_rdata`, then holds the byte at address start+j.
- R10: For a write, byte lane k of `mreq_data` carries buffer entry (bytes completed + k − chunk offset). `mreq_be` bit k is 1 exactly for the lanes from the chunk offset up to the chunk offset plus the chunk length.
- R11: A buffer write through `buf_we` while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_type | input | 2 | 00 load, 01 store, others invalid |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Transfer length in bytes |
| req_status | output | 2 | 0 none, 1 issued, 2 full, 3 error (same cycle) |
| busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle completion pulse |
| buf_we | input | 1 | Buffer byte write enable (idle only) |
| buf_widx | input | IDX_W | Buffer write index |
| buf_wdata | input | 8 | Buffer write byte |
| buf_ridx | input | IDX_W | Buffer read index |
| buf_rdata | output | 8 | Buffer read byte (combinational) |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory request accepted |
| mreq_addr | output | ADDR_W | Chunk byte address |
| mreq_write | output | 1 | 1 for store chunk, 0 for load |
| mreq_len | output | CL_W | Chunk length in bytes |
| mreq_be | output | LINE_BYTES | Byte lane enables of the chunk |
| mreq_data | output | 8*LINE_BYTES | Store data, placed by line lane |
| mrsp_valid | input | 1 | Response (read line or write ack) present |
| mrsp_ready | output | 1 | Block waits for a response |
| mrsp_data | input | 8*LINE_BYTES | Full line of read data |

## Verification
Suppose the issued or completed byte count goes wrong inside the block. The port shows it at the next request edge: `mreq_addr` steps to a wrong or unaligned address, or `mreq_len` no longer matches the remaining bytes. Suppose the lane offset is wrong. A write shows it at once in `mreq_be` and `mreq_data`. A read shows it only when the buffer is read back after `xfer_done`. A wrong completion test shows up on the final response, in the cycle after it: either `xfer_done` is missing, or an extra request appears. The vectors therefore cover several cases: offsets that cross a line, lengths that end exactly on a boundary, single-byte transfers, and full-buffer transfers.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [1:0] {
      STAT_NONE   = 2'd0,
      STAT_ISSUED = 2'd1,
      STAT_FULL   = 2'd2,
      STAT_ERROR  = 2'd3
   } dma_status_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_SEND = 2'd1,
      SQ_WAIT = 2'd2
   } seq_state_e;

   localparam logic [1:0] KIND_LOAD  = 2'b00;
   localparam logic [1:0] KIND_STORE = 2'b01;

endpackage

// File: rtl/dma_chunk_calc.sv
module dma_chunk_calc #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int LEN_W      = 9,
   parameter int OFF_W      = 6,
   parameter int CL_W       = 7
) (
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [LEN_W-1:0]  total_len,
   input  logic [LEN_W-1:0]  done_bytes,
   output logic [ADDR_W-1:0] chunk_addr,
   output logic [OFF_W-1:0]  chunk_off,
   output logic [CL_W-1:0]   chunk_len
);
   localparam int CW = ((LEN_W > CL_W) ? LEN_W : CL_W) + 1;

   logic [CW-1:0] remain;
   logic [CW-1:0] room;
   logic [CW-1:0] pick;

   // first chunk keeps the start offset, later chunks start at lane 0
   always_comb begin
      chunk_off  = (done_bytes == '0) ? start_addr[OFF_W-1:0] : '0;
      remain     = CW'(total_len) - CW'(done_bytes);
      room       = CW'(LINE_BYTES) - CW'(chunk_off);
      pick       = (remain < room) ? remain : room;
      chunk_len  = CL_W'(pick);
      chunk_addr = start_addr + ADDR_W'(done_bytes);
   end

endmodule

// File: rtl/dma_byte_buf.sv
module dma_byte_buf #(
   parameter int LINE_BYTES = 64,
   parameter int MAX_LEN    = 256,
   parameter int LEN_W      = 9,
   parameter int OFF_W      = 6,
   parameter int CL_W       = 7,
   parameter int IDX_W      = 8
) (
   input  logic                    clk,
   input  logic                    busy,
   input  logic                    host_we,
   input  logic [IDX_W-1:0]        host_widx,
   input  logic [7:0]              host_wdata,
   input  logic [IDX_W-1:0]        host_ridx,
   output logic [7:0]              host_rdata,
   input  logic [LEN_W-1:0]        base,
   input  logic [OFF_W-1:0]        off,
   input  logic [CL_W-1:0]         len,
   input  logic                    cap_en,
   input  logic [8*LINE_BYTES-1:0] cap_line,
   output logic [8*LINE_BYTES-1:0] pack_line,
   output logic [LINE_BYTES-1:0]   pack_en
);
   localparam int CW = ((LEN_W > CL_W) ? LEN_W : CL_W) + 2;
   localparam bit POW2 = ((1 << IDX_W) == MAX_LEN);

   logic [7:0]       mem [MAX_LEN];
   logic [IDX_W-1:0] lane_idx [LINE_BYTES];
   logic             lane_on  [LINE_BYTES];

   for (genvar k = 0; k < LINE_BYTES; k++) begin : g_lane
      logic [CW-1:0] rel;
      logic          in_chunk;
      assign rel      = CW'(base) + CW'(k) - CW'(off);
      assign in_chunk = (CW'(k) >= CW'(off)) && (CW'(k) < CW'(off) + CW'(len));
      if (POW2) begin : g_pow2
         assign lane_on[k] = in_chunk && (rel < CW'(MAX_LEN));
      end else begin : g_any
         assign lane_on[k] = in_chunk && (rel < CW'(MAX_LEN)) && (rel[IDX_W-1:0] < IDX_W'(MAX_LEN));
      end
      assign lane_idx[k]         = rel[IDX_W-1:0];
      assign pack_en[k]          = lane_on[k];
      assign pack_line[8*k +: 8] = lane_on[k] ? mem[lane_idx[k]] : 8'h00;
   end

   logic host_ok;
   logic rd_ok;
   if (POW2) begin : g_idx_pow2
      assign host_ok = 1'b1;
      assign rd_ok   = 1'b1;
   end else begin : g_idx_any
      assign host_ok = (host_widx < IDX_W'(MAX_LEN));
      assign rd_ok   = (host_ridx < IDX_W'(MAX_LEN));
   end

   always_ff @(posedge clk) begin
      if (cap_en) begin
         for (int k = 0; k < LINE_BYTES; k++) begin
            if (lane_on[k]) mem[lane_idx[k]] <= cap_line[8*k +: 8];
         end
      end else if (host_we && !busy && host_ok) begin
         mem[host_widx] <= host_wdata;
      end
   end

   assign host_rdata = rd_ok ? mem[host_ridx] : 8'h00;

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int MAX_LEN = 256,
   parameter int LEN_W   = 9,
   parameter int CL_W    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_type,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   output logic [1:0]        req_status,
   input  logic [CL_W-1:0]   chunk_len,
   input  logic              mreq_ready,
   input  logic              mrsp_valid,
   output logic              mreq_valid,
   output logic              mrsp_ready,
   output logic              busy,
   output logic              xfer_done,
   output logic              is_write,
   output logic              cap_en,
   output logic [ADDR_W-1:0] start_addr,
   output logic [LEN_W-1:0]  total_len,
   output logic [LEN_W-1:0]  done_bytes
);
   seq_state_e       state;
   logic [LEN_W-1:0] sent_bytes;
   logic             kind_ok;
   logic             len_ok;
   logic             accept;

   assign kind_ok = (req_type == KIND_LOAD) || (req_type == KIND_STORE);
   assign len_ok  = (req_len != '0) && (req_len <= LEN_W'(MAX_LEN));

   always_comb begin
      if (!req_valid)                req_status = STAT_NONE;
      else if (state != SQ_IDLE)     req_status = STAT_FULL;
      else if (!kind_ok || !len_ok)  req_status = STAT_ERROR;
      else                           req_status = STAT_ISSUED;
   end

   assign accept     = (req_status == STAT_ISSUED);
   assign busy       = (state != SQ_IDLE);
   assign mreq_valid = (state == SQ_SEND);
   assign mrsp_ready = (state == SQ_WAIT);
   assign cap_en     = (state == SQ_WAIT) && mrsp_valid && !is_write;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= SQ_IDLE;
         sent_bytes <= '0;
         done_bytes <= '0;
         start_addr <= '0;
         total_len  <= '0;
         is_write   <= 1'b0;
         xfer_done  <= 1'b0;
      end else begin
         xfer_done <= 1'b0;
         unique case (state)
            SQ_IDLE: if (accept) begin
               start_addr <= req_addr;
               total_len  <= req_len;
               is_write   <= (req_type == KIND_STORE);
               sent_bytes <= '0;
               done_bytes <= '0;
               state      <= SQ_SEND;
            end
            SQ_SEND: if (mreq_ready) begin
               sent_bytes <= sent_bytes + LEN_W'(chunk_len);
               state      <= SQ_WAIT;
            end
            SQ_WAIT: if (mrsp_valid) begin
               done_bytes <= sent_bytes;
               if (sent_bytes == total_len) begin
                  state     <= SQ_IDLE;
                  xfer_done <= 1'b1;
               end else begin
                  state <= SQ_SEND;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   // R7
   sent_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (sent_bytes <= total_len) && (done_bytes <= sent_bytes));

   // R3
   refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && busy) |=> ($stable(start_addr) && $stable(total_len)));

endmodule

// File: rtl/dma_line_seq.sv
module dma_line_seq #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int MAX_LEN    = 256,
   localparam int LEN_W     = $clog2(MAX_LEN + 1),
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int CL_W      = $clog2(LINE_BYTES + 1),
   localparam int IDX_W     = $clog2(MAX_LEN)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [1:0]              req_type,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [LEN_W-1:0]        req_len,
   output logic [1:0]              req_status,
   output logic                    busy,
   output logic                    xfer_done,
   input  logic                    buf_we,
   input  logic [IDX_W-1:0]        buf_widx,
   input  logic [7:0]              buf_wdata,
   input  logic [IDX_W-1:0]        buf_ridx,
   output logic [7:0]              buf_rdata,
   output logic                    mreq_valid,
   input  logic                    mreq_ready,
   output logic [ADDR_W-1:0]       mreq_addr,
   output logic                    mreq_write,
   output logic [CL_W-1:0]         mreq_len,
   output logic [LINE_BYTES-1:0]   mreq_be,
   output logic [8*LINE_BYTES-1:0] mreq_data,
   input  logic                    mrsp_valid,
   output logic                    mrsp_ready,
   input  logic [8*LINE_BYTES-1:0] mrsp_data
);
   if ((LINE_BYTES < 2) || ((1 << OFF_W) != LINE_BYTES)) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 2");
   end
   if (MAX_LEN < 2) begin : g_bad_len
      $error("MAX_LEN must be at least 2");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W must exceed the line offset width");
   end

   logic [ADDR_W-1:0] start_addr;
   logic [LEN_W-1:0]  total_len;
   logic [LEN_W-1:0]  done_bytes;
   logic [OFF_W-1:0]  chunk_off;
   logic [CL_W-1:0]   chunk_len;
   logic              cap_en;
   logic              is_write;

   dma_seq_ctrl #(
      .ADDR_W (ADDR_W), .MAX_LEN (MAX_LEN), .LEN_W (LEN_W), .CL_W (CL_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_type   (req_type),
      .req_addr   (req_addr),
      .req_len    (req_len),
      .req_status (req_status),
      .chunk_len  (chunk_len),
      .mreq_ready (mreq_ready),
      .mrsp_valid (mrsp_valid),
      .mreq_valid (mreq_valid),
      .mrsp_ready (mrsp_ready),
      .busy       (busy),
      .xfer_done  (xfer_done),
      .is_write   (is_write),
      .cap_en     (cap_en),
      .start_addr (start_addr),
      .total_len  (total_len),
      .done_bytes (done_bytes)
   );

   dma_chunk_calc #(
      .ADDR_W (ADDR_W), .LINE_BYTES (LINE_BYTES), .LEN_W (LEN_W),
      .OFF_W (OFF_W), .CL_W (CL_W)
   ) u_calc (
      .start_addr (start_addr),
      .total_len  (total_len),
      .done_bytes (done_bytes),
      .chunk_addr (mreq_addr),
      .chunk_off  (chunk_off),
      .chunk_len  (chunk_len)
   );

   dma_byte_buf #(
      .LINE_BYTES (LINE_BYTES), .MAX_LEN (MAX_LEN), .LEN_W (LEN_W),
      .OFF_W (OFF_W), .CL_W (CL_W), .IDX_W (IDX_W)
   ) u_buf (
      .clk        (clk),
      .busy       (busy),
      .host_we    (buf_we),
      .host_widx  (buf_widx),
      .host_wdata (buf_wdata),
      .host_ridx  (buf_ridx),
      .host_rdata (buf_rdata),
      .base       (done_bytes),
      .off        (chunk_off),
      .len        (chunk_len),
      .cap_en     (cap_en),
      .cap_line   (mrsp_data),
      .pack_line  (mreq_data),
      .pack_en    (mreq_be)
   );

   assign mreq_write = is_write;
   assign mreq_len   = chunk_len;

   // R5
   chunk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mreq_valid |-> (mreq_len != '0) && (mreq_len <= CL_W'(LINE_BYTES))
                     && ($countones(mreq_be) == int'(mreq_len)));

   // R6
   later_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq_valid && (done_bytes != '0)) |-> (mreq_addr[OFF_W-1:0] == '0));

   // R7
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr) && $stable(mreq_len)));

   // R7
   single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq_valid && mreq_ready) |=> (!mreq_valid && mrsp_ready));

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> (!busy && $past(mrsp_valid && mrsp_ready)));

endmodule

// File: tb/dma_line_seq_bench.sv
module dma_line_seq_bench;
   localparam int LINE = 64;
   localparam int MAXL = 256;
   localparam int NV   = 8;

   // stimulus table: kind (0 load, 1 store), start address, length, ready stall
   localparam logic [1:0]  V_KIND  [NV] = '{2'd1, 2'd0, 2'd0, 2'd1, 2'd0, 2'd1, 2'd0, 2'd1};
   localparam logic [31:0] V_ADDR  [NV] = '{32'h1000, 32'h1010, 32'h1030, 32'h203F,
                                            32'h3000, 32'h40F0, 32'h5001, 32'h6020};
   localparam int          V_LEN   [NV] = '{64, 16, 100, 130, 256, 256, 1, 32};
   localparam int          V_STALL [NV] = '{0, 1, 0, 2, 2, 1, 0, 3};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [1:0]   req_type = 2'b00;
   logic [31:0]  req_addr = '0;
   logic [8:0]   req_len = '0;
   logic [1:0]   req_status;
   logic         busy, xfer_done;
   logic         buf_we = 1'b0;
   logic [7:0]   buf_widx = '0, buf_wdata = '0, buf_ridx = '0;
   logic [7:0]   buf_rdata;
   logic         mreq_valid, mreq_write, mrsp_ready;
   logic         mreq_ready = 1'b0;
   logic [31:0]  mreq_addr;
   logic [6:0]   mreq_len;
   logic [63:0]  mreq_be;
   logic [511:0] mreq_data;
   logic         mrsp_valid = 1'b0;
   logic [511:0] mrsp_data = '0;

   int   n_checks = 0;
   int   n_fails  = 0;
   logic [7:0] src [MAXL];

   always #4 clk = ~clk;

   dma_line_seq u_dma_line_seq (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_type (req_type), .req_addr (req_addr),
      .req_len (req_len), .req_status (req_status), .busy (busy), .xfer_done (xfer_done),
      .buf_we (buf_we), .buf_widx (buf_widx), .buf_wdata (buf_wdata),
      .buf_ridx (buf_ridx), .buf_rdata (buf_rdata),
      .mreq_valid (mreq_valid), .mreq_ready (mreq_ready), .mreq_addr (mreq_addr),
      .mreq_write (mreq_write), .mreq_len (mreq_len), .mreq_be (mreq_be),
      .mreq_data (mreq_data), .mrsp_valid (mrsp_valid), .mrsp_ready (mrsp_ready),
      .mrsp_data (mrsp_data)
   );

   function automatic logic [7:0] mem_byte(input logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h3C;
   endfunction

   task automatic check(input bit ok, input string rq, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   task automatic drive_req(input logic [1:0] ty, input logic [31:0] a, input int ln);
      req_valid = 1'b1;
      req_type  = ty;
      req_addr  = a;
      req_len   = 9'(ln);
   endtask

   // runs one table entry; preissued = request already accepted by the caller
   task automatic run_xfer(input int i, input bit preissued, input int chain);
      logic [31:0] cur;
      int left, n, room, bad, waitc, slot;
      bit first, wr;
      logic [31:0] held;
      wr = (V_KIND[i] == 2'd1);
      if (wr && !preissued) begin
         for (int j = 0; j < V_LEN[i]; j++) begin
            src[j]    = 8'(j * 7 + i * 13);
            buf_we    = 1'b1;
            buf_widx  = 8'(j);
            buf_wdata = src[j];
            @(posedge clk); @(negedge clk);
         end
         buf_we = 1'b0;
      end
      if (!preissued) begin
         drive_req(V_KIND[i], V_ADDR[i], V_LEN[i]);
         #1 check(req_status == 2'd1, "R2", "status on accept", req_status, 1);
         @(posedge clk); @(negedge clk);
         req_valid = 1'b0;
         check(busy == 1'b1, "R2", "busy after accept", busy, 1);
      end
      cur = V_ADDR[i];
      left = V_LEN[i];
      first = 1'b1;
      while (left > 0) begin
         waitc = 0;
         while (!mreq_valid && waitc < 20) begin
            @(posedge clk); @(negedge clk);
            waitc++;
         end
         room = LINE - int'(cur % LINE);
         n = (left < room) ? left : room;
         check(mreq_valid && mreq_addr == cur, first ? "R5" : "R6", "chunk address", mreq_addr, cur);
         check(int'(mreq_len) == n && mreq_write == wr, first ? "R5" : "R6", "chunk length", mreq_len, n);
         if (wr) begin
            bad = 0;
            for (int k = 0; k < LINE; k++) begin
               slot = int'(cur - V_ADDR[i]) + k - int'(cur % LINE);
               if (k >= int'(cur % LINE) && k < int'(cur % LINE) + n) begin
                  if (!mreq_be[k] || mreq_data[8*k +: 8] != src[slot]) bad++;
               end else if (mreq_be[k]) bad++;
            end
            check(bad == 0, "R10", "store lanes mismatching", bad, 0);
         end
         held = mreq_addr;
         for (int s = 0; s < V_STALL[i]; s++) begin
            @(posedge clk); @(negedge clk);
            check(mreq_valid && mreq_addr == held, "R7", "request held while not ready", mreq_addr, held);
         end
         mreq_ready = 1'b1;
         @(posedge clk); @(negedge clk);
         mreq_ready = 1'b0;
         check(!mreq_valid && mrsp_ready, "R7", "no second request in flight", mreq_valid, 0);
         if (first) begin
            drive_req(2'b00, 32'hDEAD0000, 5);
            #1 check(req_status == 2'd2, "R3", "status while busy", req_status, 2);
            @(posedge clk); @(negedge clk);
            req_valid = 1'b0;
            if (wr && V_LEN[i] > n) begin
               buf_we    = 1'b1;
               buf_widx  = 8'(V_LEN[i] - 1);
               buf_wdata = ~src[V_LEN[i] - 1];
               @(posedge clk); @(negedge clk);
               buf_we = 1'b0;
            end
         end
         @(posedge clk); @(negedge clk);
         check(!mreq_valid, "R7", "idle while awaiting response", mreq_valid, 0);
         for (int k = 0; k < LINE; k++)
            mrsp_data[8*k +: 8] = mem_byte((cur & ~32'(LINE - 1)) + 32'(k));
         mrsp_valid = 1'b1;
         @(posedge clk); @(negedge clk);
         mrsp_valid = 1'b0;
         left -= n;
         cur  += 32'(n);
         first = 1'b0;
         if (left > 0)
            check(xfer_done == 1'b0, "R8", "no done before last chunk", xfer_done, 0);
         else begin
            check(xfer_done && !busy, "R8", "done pulse with busy low", {xfer_done, busy}, 2'b10);
            if (chain >= 0) begin
               drive_req(V_KIND[chain], V_ADDR[chain], V_LEN[chain]);
               #1 check(req_status == 2'd1, "R8", "accept in completion cycle", req_status, 1);
               @(posedge clk); @(negedge clk);
               req_valid = 1'b0;
               check(!xfer_done && busy, "R8", "single-cycle pulse, new transfer busy", {xfer_done, busy}, 2'b01);
            end else begin
               @(posedge clk); @(negedge clk);
               check(!xfer_done, "R8", "done lasts one cycle", xfer_done, 0);
            end
         end
      end
      if (!wr) begin
         bad = 0;
         for (int j = 0; j < V_LEN[i]; j++) begin
            buf_ridx = 8'(j);
            #1 if (buf_rdata != mem_byte(V_ADDR[i] + 32'(j))) bad++;
         end
         check(bad == 0, "R9", "read buffer bytes mismatching", bad, 0);
      end
   endtask

   task automatic reject(input logic [1:0] ty, input int ln, input string what);
      drive_req(ty, 32'h7000, ln);
      #1 check(req_status == 2'd3, "R4", what, req_status, 3);
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      check(!busy && !mreq_valid, "R4", {what, " left idle"}, {busy, mreq_valid}, 0);
      @(posedge clk); @(negedge clk);
      check(!mreq_valid, "R4", {what, " no request"}, mreq_valid, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !mreq_valid && !xfer_done, "R1", "reset state", {busy, mreq_valid, xfer_done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !mreq_valid && !xfer_done, "R1", "state after reset release",
            {busy, mreq_valid, xfer_done}, 0);
      #1 check(req_status == 2'd0, "R4", "no request status", req_status, 0);

      for (int i = 0; i < NV; i++) run_xfer(i, 1'b0, -1);

      // R4 rejects
      reject(2'b10, 4, "invalid kind 2");
      reject(2'b11, 4, "invalid kind 3");
      reject(2'b00, 0, "zero length");
      reject(2'b01, MAXL + 1, "oversize length");

      // R8 back-to-back: a store whose completion cycle accepts a load
      run_xfer(7, 1'b0, 6);
      run_xfer(6, 1'b1, -1);

      // R11 checked again: idle write still lands, read back directly
      buf_we = 1'b1; buf_widx = 8'd200; buf_wdata = 8'h5E;
      @(posedge clk); @(negedge clk);
      buf_we = 1'b0; buf_ridx = 8'd200;
      #1 check(buf_rdata == 8'h5E, "R11", "idle buffer write lands", buf_rdata, 8'h5E);

      summary();
   end

endmodule